// File: doc/BRIEF.md
# Energy-Gated Radio Burst Sequencer

This block decides when a harvesting-powered sensor node may spend energy on a radio burst. A period counter, advanced by a slow tick enable, asks an external ADC at fixed intervals for a conversion of the stored supply voltage. The returned code is compared against a programmable threshold. The radio is brought up only when the supply is high enough and there is something to send.

Data is waiting to be sent when continuous streaming mode is selected, or when an event input has pulsed since the last burst was granted. Power-up is a fixed sequence. The oscillator enable comes on first and stays on for a settling window. The transmitter enable then comes on for a burst window, and a one-cycle start pulse tells the downstream packetizer to begin framing: header first, then payload, then CRC. When the burst window ends, both enables drop together and the block goes back to waiting for the next supply check.

Intervals are whole counts of the tick, so one tick source covers the multi-second check period, the millisecond settling time and the sub-millisecond burst. A denied check keeps the request waiting. An event that arrives while the radio is up is held and served by a later granted check.

Top module: `tx_power_sequencer`

## Requirements
- R1: While rst is high and in the cycle after it is released, adc_req, osc_en, tx_en and pkt_start are all 0.
- R2: adc_req rises once every PERIOD_TICKS ticks, counted from reset, when the radio is idle. It stays high until the cycle in which adc_valid is seen.
- R3: A conversion is accepted when adc_data >= thresh (unsigned). With data waiting, osc_en goes high in the cycle after adc_valid. A code one below thresh leaves osc_en low.
- R4: Data is waiting when stream_en is 1 or an event is latched. With neither, an accepted conversion leaves osc_en low.
- R5: osc_en is high for exactly SETTLE_TICKS ticks before tx_en rises.
- R6: tx_en is high for exactly BURST_TICKS ticks. osc_en and tx_en then fall in the same cycle.
- R7: pkt_start is high for exactly one cycle per burst, and that cycle is the first cycle in which tx_en is high.
- R8: After a denied check, a latched event stays latched and is served by a later check that passes.
- R9: An event_in pulse during settling or the burst is held. It is served by the next passing check with no further event. Once served, it is cleared.
- R10: While tick is 0, no window advances. osc_en and tx_en hold their values.
- R11: tx_en is never high while osc_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow time-base enable; all intervals count these |
| thresh | input | ADC_W | Minimum supply code that allows a burst |
| stream_en | input | 1 | 1 = continuous streaming, data always waiting |
| event_in | input | 1 | One-cycle pulse marking a detected rare event |
| adc_req | output | 1 | Conversion request, held until answered |
| adc_valid | input | 1 | Conversion result present on adc_data |
| adc_data | input | ADC_W | Digitized supply voltage |
| osc_en | output | 1 | Crystal oscillator enable |
| tx_en | output | 1 | Transmitter enable |
| pkt_start | output | 1 | One-cycle start for the packetizer |

## Verification
The hardest case to reach is an event that lands while the radio is already up. To get there, an event must first be latched and its burst granted, and then a second pulse must be placed inside the transmit window. The bench waits for tx_en to rise before pulsing event_in. It then shows that the following passing check raises osc_en with no new stimulus, and that the check after that does not. A denied check is produced in the same way, by returning a code one below the threshold while an event is pending.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_SETTLE = 2'd2,
    ST_BURST  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/tick_window.sv
module tick_window #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign done = run && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R5
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> (cnt == $past(cnt) || !$past(run))); // R10
endmodule

// File: rtl/event_holder.sv
module event_holder (
  input  logic clk,
  input  logic rst,
  input  logic event_in,
  input  logic claim,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else     pending <= event_in || (pending && !claim);
  end

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
    event_in |=> pending); // R9
endmodule

// File: rtl/tx_power_sequencer.sv
module tx_power_sequencer #(
  parameter int ADC_W        = 10,
  parameter int PERIOD_TICKS = 100000,
  parameter int SETTLE_TICKS = 400,
  parameter int BURST_TICKS  = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [ADC_W-1:0] thresh,
  input  logic             stream_en,
  input  logic             event_in,
  output logic             adc_req,
  input  logic             adc_valid,
  input  logic [ADC_W-1:0] adc_data,
  output logic             osc_en,
  output logic             tx_en,
  output logic             pkt_start
);
  import seq_pkg::*;

  localparam int NWIN = 3;
  localparam int WIN_PERIOD = 0;
  localparam int WIN_SETTLE = 1;
  localparam int WIN_BURST  = 2;

  seq_state_t state;
  logic       check_pend;
  logic       evt_pend;
  logic       grant;
  logic       energy_ok;
  logic [NWIN-1:0] win_run;
  logic [NWIN-1:0] win_done;

  assign win_run[WIN_PERIOD] = 1'b1;
  assign win_run[WIN_SETTLE] = (state == ST_SETTLE);
  assign win_run[WIN_BURST]  = (state == ST_BURST);

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam int LIM = (g == WIN_PERIOD) ? PERIOD_TICKS :
                         (g == WIN_SETTLE) ? SETTLE_TICKS : BURST_TICKS;
    tick_window #(.LIMIT(LIM)) i_win (
      .clk (clk),
      .rst (rst),
      .run (win_run[g]),
      .tick(tick),
      .done(win_done[g])
    );
  end

  assign energy_ok = (adc_data >= thresh);
  assign grant = (state == ST_SAMPLE) && adc_valid && energy_ok &&
                 (stream_en || evt_pend);

  event_holder i_evt (
    .clk     (clk),
    .rst     (rst),
    .event_in(event_in),
    .claim   (grant),
    .pending (evt_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      check_pend <= 1'b0;
    end else if (win_done[WIN_PERIOD]) begin
      check_pend <= 1'b1;
    end else if (state == ST_IDLE && check_pend) begin
      check_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      adc_req   <= 1'b0;
      osc_en    <= 1'b0;
      tx_en     <= 1'b0;
      pkt_start <= 1'b0;
    end else begin
      pkt_start <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (check_pend) begin
            state   <= ST_SAMPLE;
            adc_req <= 1'b1;
          end
        end
        ST_SAMPLE: begin
          if (adc_valid) begin
            adc_req <= 1'b0;
            if (grant) begin
              state  <= ST_SETTLE;
              osc_en <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_SETTLE: begin
          if (win_done[WIN_SETTLE]) begin
            state     <= ST_BURST;
            tx_en     <= 1'b1;
            pkt_start <= 1'b1;
          end
        end
        ST_BURST: begin
          if (win_done[WIN_BURST]) begin
            state  <= ST_IDLE;
            tx_en  <= 1'b0;
            osc_en <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_TX_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
    tx_en |-> osc_en); // R11
  AST_PKT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pkt_start |=> !pkt_start); // R7
  AST_PKT_AT_TX_RISE: assert property (@(posedge clk) disable iff (rst)
    pkt_start |-> (tx_en && !$past(tx_en))); // R7
  AST_OSC_NEEDS_ENERGY: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_en) |-> ($past(adc_valid) && $past(adc_data >= thresh))); // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (adc_req && !adc_valid) |=> adc_req); // R2
  AST_NO_REQ_RADIO_UP: assert property (@(posedge clk) disable iff (rst)
    adc_req |-> !osc_en); // R2
  AST_DROP_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en) |-> !osc_en); // R6
endmodule

// File: tb/test_tx_power_sequencer.sv
module test_tx_power_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int PER = 40;
  localparam int SET = 6;
  localparam int BUR = 4;
  localparam logic [AW-1:0] TH = 10'd500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic [AW-1:0] thresh = TH;
  logic stream_en = 1'b0;
  logic event_in = 1'b0;
  logic adc_valid = 1'b0;
  logic [AW-1:0] adc_data = '0;
  logic adc_req, osc_en, tx_en, pkt_start;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) cyc++;

  tx_power_sequencer #(
    .ADC_W(AW), .PERIOD_TICKS(PER), .SETTLE_TICKS(SET), .BURST_TICKS(BUR)
  ) i_tx_power_sequencer (
    .clk(clk), .rst(rst), .tick(tick), .thresh(thresh),
    .stream_en(stream_en), .event_in(event_in), .adc_req(adc_req),
    .adc_valid(adc_valid), .adc_data(adc_data), .osc_en(osc_en),
    .tx_en(tx_en), .pkt_start(pkt_start)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_req(output int at);
    int n = 0;
    while (!adc_req && n < 400) begin @(negedge clk); n++; end
    chk(adc_req == 1'b1, "R2 request seen", adc_req, 1);
    at = cyc;
  endtask

  task automatic respond(input logic [AW-1:0] code);
    adc_valid = 1'b1; adc_data = code;
    @(negedge clk);
    adc_valid = 1'b0;
  endtask

  task automatic pulse_event();
    event_in = 1'b1; @(negedge clk); event_in = 1'b0;
  endtask

  task automatic run_radio(input string tag);
    int s = 0, b = 0, pk = 0, n = 0;
    bit osc_ok = 1'b1;
    while (osc_en && !tx_en && n < 200) begin s++; n++; @(negedge clk); end
    chk(s == SET, "R5 settle length", s, SET);
    chk(pkt_start == 1'b1, "R7 start at first tx cycle", pkt_start, 1);
    while (tx_en && n < 400) begin
      b++; n++; pk += int'(pkt_start);
      if (!osc_en) osc_ok = 1'b0;
      @(negedge clk);
    end
    chk(b == BUR, "R6 burst length", b, BUR);
    chk(pk == 1, "R7 start pulse count", pk, 1);
    chk(osc_ok, "R11 osc held during tx", osc_ok, 1);
    chk(osc_en == 1'b0, "R6 osc drops with tx", osc_en, 0);
    $display("  radio sequence %s done", tag);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk({adc_req, osc_en, tx_en, pkt_start} == 4'b0, "R1 outputs in reset",
        {adc_req, osc_en, tx_en, pkt_start}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({adc_req, osc_en, tx_en, pkt_start} == 4'b0, "R1 outputs after reset",
        {adc_req, osc_en, tx_en, pkt_start}, 0);
  endtask

  task automatic t_period();
    int a1, a2;
    wait_req(a1);
    repeat (3) @(negedge clk);
    chk(adc_req == 1'b1, "R2 request held unanswered", adc_req, 1);
    respond(TH - 1'b1);
    chk(adc_req == 1'b0, "R2 request cleared", adc_req, 0);
    wait_req(a2);
    chk(a2 - a1 == PER, "R2 check interval", a2 - a1, PER);
    respond(TH - 1'b1);
  endtask

  task automatic t_no_pending();
    int a;
    wait_req(a);
    respond(10'h3FF);
    chk(osc_en == 1'b0, "R4 nothing waiting keeps radio off", osc_en, 0);
    repeat (3) @(negedge clk);
    chk(osc_en == 1'b0, "R4 radio still off", osc_en, 0);
  endtask

  task automatic t_stream();
    int a;
    stream_en = 1'b1;
    wait_req(a);
    respond(TH);
    chk(osc_en == 1'b1 && tx_en == 1'b0, "R3 equal code grants", osc_en, 1);
    run_radio("stream");
    stream_en = 1'b0;
  endtask

  task automatic t_denied();
    int a;
    pulse_event();
    wait_req(a);
    respond(TH - 1'b1);
    chk(osc_en == 1'b0, "R3 code below threshold denied", osc_en, 0);
    wait_req(a);
    respond(TH);
    chk(osc_en == 1'b1, "R8 latched event served later", osc_en, 1);
    run_radio("denied-then-served");
  endtask

  task automatic t_queue();
    int a, n = 0;
    pulse_event();
    wait_req(a);
    respond(10'd800);
    chk(osc_en == 1'b1, "R9 first event granted", osc_en, 1);
    while (!tx_en && n < 200) begin @(negedge clk); n++; end
    pulse_event();
    while (tx_en && n < 400) begin @(negedge clk); n++; end
    chk(osc_en == 1'b0, "R9 first burst ended", osc_en, 0);
    wait_req(a);
    respond(10'd800);
    chk(osc_en == 1'b1, "R9 queued event served", osc_en, 1);
    run_radio("queued");
    wait_req(a);
    respond(10'd800);
    chk(osc_en == 1'b0, "R9 served event cleared", osc_en, 0);
  endtask

  task automatic t_freeze();
    int a, n = 0;
    bit held = 1'b1;
    stream_en = 1'b1;
    wait_req(a);
    respond(TH);
    tick = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!(osc_en && !tx_en)) held = 1'b0;
    end
    chk(held, "R10 windows frozen without tick", held, 1);
    tick = 1'b1;
    while (!tx_en && n < 200) begin @(negedge clk); n++; end
    chk(tx_en == 1'b1, "R10 resumes after tick returns", tx_en, 1);
    while (tx_en && n < 400) begin @(negedge clk); n++; end
    stream_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_period();
    t_no_pending();
    t_stream();
    t_denied();
    t_queue();
    t_freeze();
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule